// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This controller moves a small microcontroller core between normal running, idle and power-down, and brings it back out again. In idle the core clock is gated while the oscillator keeps running. In power-down the oscillator is switched off as well, so RAM and register contents are held only because nothing is clocked. The controller itself runs from an always-on clock. It tells the clock generator when to run, tells the core when its clock may tick, and forces the ALE, PSEN and port pins to fixed states while the core is asleep.

Power-down is left in one of two ways. The first is a hardware reset, which re-initialises the special function registers but keeps RAM. The second is a qualified external interrupt, which keeps both. An interrupt wakeup has two phases. While the pin is held low, the oscillator is restarted and given a stability count. The wakeup completes only when the pin goes high again after that count. A reset that ends idle opens a short window in which the core still runs but cannot reach internal RAM. The register reset strobe follows that window.

States: RUN, IDLE, IDLE_RST (reset inhibit window), PD_SLEEP (oscillator off), PD_WAKE (oscillator restarted, counting stability), PD_RELEASE (stable, waiting for pin release), INT_TAKE (interrupt-taken pulse), RESET_SYNC (register reset strobe). Transitions:
- RUN→RESET_SYNC on reset. RUN→PD_SLEEP on a power-down request. RUN→IDLE on an idle request.
- IDLE→IDLE_RST on reset. IDLE→INT_TAKE on any enabled interrupt pin low.
- IDLE_RST→RESET_SYNC after INHIBIT_CYCLES cycles.
- PD_SLEEP→PD_WAKE on a qualified level wake.
- PD_WAKE→PD_SLEEP on early release. PD_WAKE→PD_RELEASE when the count completes.
- PD_RELEASE→INT_TAKE on pin release.
- Every power-down state goes to RESET_SYNC on reset.
- INT_TAKE→RUN.
- RESET_SYNC→RUN once reset is gone.

Top module: `pwr_mode_seq`

## Requirements
- R1: A power-down request in RUN switches the oscillator and core clock off from the next cycle, and it wins over a simultaneous idle request.
- R2: In idle the oscillator runs, the core clock is gated, and ALE and PSEN are forced to 1. Port codes use 2 bits per port, port n at bits [2n+1:2n], with 00 = core, 01 = latched data, 10 = address, 11 = float. In idle, port_sel is 8'h55 with internal program memory and 8'h67 with external program memory (port 0 floats, port 2 carries the address).
- R3: In every power-down state, ALE and PSEN are forced to 0. port_sel is 8'h55 with internal program memory and 8'h57 with external program memory (port 0 floats, port 2 holds latched data).
- R4: Only an interrupt pin that is low, enabled and configured level-sensitive (int_level bit 1) wakes the block from power-down. A disabled or edge-configured pin leaves the oscillator off.
- R5: While a qualified wake pin stays low, the oscillator is enabled. The block counts STABLE_CYCLES cycles with osc_ready high, and it pauses while osc_ready is low. The block keeps the core asleep for as long as the pin stays low.
- R6: If the wake pin is released before the count completes, the oscillator goes off again and the count restarts from zero on the next attempt.
- R7: After a completed count, the return of the pin to high gives a single-cycle int_taken with the core clock running, followed by RUN.
- R8: A reset during idle holds ram_inhibit high with the core clock running and no pin forcing for INHIBIT_CYCLES cycles. One cycle of sfr_rst follows, then RUN.
- R9: A reset in any power-down state goes straight to one sfr_rst cycle without a RAM inhibit window, even during a wakeup.
- R10: In idle, any enabled interrupt pin held low ends idle with an int_taken pulse, whatever its level or edge setting.
- R11: Block reset puts the sequencer in the register-reset state (sfr_rst high, oscillator on). sfr_rst stays high while hw_reset is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| hw_reset | input | 1 | Chip hardware reset request |
| req_idle | input | 1 | Software idle request |
| req_pdown | input | 1 | Software power-down request |
| int_n | input | NUM_INT | External interrupt pins, active low |
| int_en | input | NUM_INT | Per-pin interrupt enable |
| int_level | input | NUM_INT | Per-pin level-sensitive select (0 = edge) |
| osc_ready | input | 1 | Oscillator running indication |
| prog_ext | input | 1 | Program memory is external |
| osc_en | output | 1 | Oscillator enable |
| core_clk_en | output | 1 | Core clock gate enable |
| ram_inhibit | output | 1 | Internal RAM access block |
| sfr_rst | output | 1 | Register-file reset strobe |
| int_taken | output | 1 | Wake interrupt accepted pulse |
| pin_force | output | 1 | Pin overrides active |
| ale_val | output | 1 | Forced ALE level |
| psen_val | output | 1 | Forced PSEN level |
| port_sel | output | 2*PORT_CNT | Per-port source code |

## Verification
The bound checker watches, on every cycle, the relations between the outputs. It checks that a stopped oscillator always comes with power-down pin levels and a gated core. It checks that the idle pin levels always come with a running oscillator, that the RAM inhibit window never overlaps pin forcing, that int_taken never lasts more than one cycle, and that a sleeping block stays asleep without a qualified level wake. It also checks that reset in power-down or idle leads to the right next state. Only the bench scenarios show the things that depend on a sequence. These are that the stability count pauses on osc_ready and restarts after an early release, that the wakeup completes only on pin release, that the inhibit window has its exact length, and that the port codes match the program-memory setting.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

    typedef enum logic [2:0] {
        ST_RUN,
        ST_IDLE,
        ST_IDLE_RST,
        ST_PD_SLEEP,
        ST_PD_WAKE,
        ST_PD_RELEASE,
        ST_INT_TAKE,
        ST_RESET_SYNC
    } seq_state_e;

    typedef enum logic [1:0] {
        PM_NONE,
        PM_IDLE,
        PM_PDOWN
    } pin_mode_e;

    typedef enum logic [1:0] {
        PIN_CORE  = 2'b00,
        PIN_LATCH = 2'b01,
        PIN_ADDR  = 2'b10,
        PIN_FLOAT = 2'b11
    } pin_src_e;

    localparam int FLOAT_PORT = 0;
    localparam int ADDR_PORT  = 2;

endpackage

// File: rtl/pwr_wake_qual.sv
module pwr_wake_qual #(
    parameter int NUM_INT = 2
) (
    input  logic [NUM_INT-1:0] int_n,
    input  logic [NUM_INT-1:0] int_en,
    input  logic [NUM_INT-1:0] int_level,
    output logic               wake_level,
    output logic               wake_any
);

    logic [NUM_INT-1:0] pin_active;
    logic [NUM_INT-1:0] pin_level_ok;

    for (genvar i = 0; i < NUM_INT; i++) begin : g_pin
        assign pin_active[i]   = int_en[i] & ~int_n[i];
        assign pin_level_ok[i] = pin_active[i] & int_level[i];
    end

    assign wake_level = |pin_level_ok;
    assign wake_any   = |pin_active;

endmodule

// File: rtl/pwr_cycle_cnt.sv
module pwr_cycle_cnt #(
    parameter int LIMIT_VAL = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic tick,
    output logic done
);

    localparam int CW = (LIMIT_VAL < 1) ? 1 : $clog2(LIMIT_VAL + 1);
    localparam logic [CW-1:0] LIMIT = CW'(LIMIT_VAL);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clear) begin
            cnt <= '0;
        end else if (tick && (cnt != LIMIT)) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign done = (cnt == LIMIT);

endmodule

// File: rtl/pwr_pin_table.sv
module pwr_pin_table
    import pwr_mode_pkg::*;
#(
    parameter int PORT_CNT = 4
) (
    input  pin_mode_e               mode,
    input  logic                    prog_ext,
    output logic                    force_en,
    output logic                    ale_val,
    output logic                    psen_val,
    output logic [2*PORT_CNT-1:0]   port_sel
);

    for (genvar p = 0; p < PORT_CNT; p++) begin : g_port
        pin_src_e src;
        always_comb begin
            unique case (mode)
                PM_IDLE: begin
                    if (prog_ext && (p == FLOAT_PORT))     src = PIN_FLOAT;
                    else if (prog_ext && (p == ADDR_PORT)) src = PIN_ADDR;
                    else                                   src = PIN_LATCH;
                end
                PM_PDOWN: begin
                    if (prog_ext && (p == FLOAT_PORT))     src = PIN_FLOAT;
                    else                                   src = PIN_LATCH;
                end
                default: src = PIN_CORE;
            endcase
        end
        assign port_sel[2*p +: 2] = src;
    end

    assign force_en = (mode != PM_NONE);
    assign ale_val  = (mode == PM_IDLE);
    assign psen_val = (mode == PM_IDLE);

endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
    import pwr_mode_pkg::*;
#(
    parameter int NUM_INT        = 2,
    parameter int PORT_CNT       = 4,
    parameter int STABLE_CYCLES  = 160000,
    parameter int INHIBIT_CYCLES = 24
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  hw_reset,
    input  logic                  req_idle,
    input  logic                  req_pdown,
    input  logic [NUM_INT-1:0]    int_n,
    input  logic [NUM_INT-1:0]    int_en,
    input  logic [NUM_INT-1:0]    int_level,
    input  logic                  osc_ready,
    input  logic                  prog_ext,
    output logic                  osc_en,
    output logic                  core_clk_en,
    output logic                  ram_inhibit,
    output logic                  sfr_rst,
    output logic                  int_taken,
    output logic                  pin_force,
    output logic                  ale_val,
    output logic                  psen_val,
    output logic [2*PORT_CNT-1:0] port_sel
);

    localparam int INH_LIMIT = (INHIBIT_CYCLES < 2) ? 1 : INHIBIT_CYCLES - 1;

    seq_state_e state_q;
    seq_state_e state_d;
    pin_mode_e  pin_mode;
    logic       wake_level;
    logic       wake_any;
    logic       stable_done;
    logic       inhibit_done;

    pwr_wake_qual #(.NUM_INT(NUM_INT)) u_wake (
        .int_n      (int_n),
        .int_en     (int_en),
        .int_level  (int_level),
        .wake_level (wake_level),
        .wake_any   (wake_any)
    );

    pwr_cycle_cnt #(.LIMIT_VAL(STABLE_CYCLES)) u_stable (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (state_q != ST_PD_WAKE),
        .tick  (osc_ready),
        .done  (stable_done)
    );

    pwr_cycle_cnt #(.LIMIT_VAL(INH_LIMIT)) u_inhibit (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (state_q != ST_IDLE_RST),
        .tick  (1'b1),
        .done  (inhibit_done)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RESET_SYNC;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (hw_reset)       state_d = ST_RESET_SYNC;
                else if (req_pdown) state_d = ST_PD_SLEEP;
                else if (req_idle)  state_d = ST_IDLE;
            end
            ST_IDLE: begin
                if (hw_reset)       state_d = ST_IDLE_RST;
                else if (wake_any)  state_d = ST_INT_TAKE;
            end
            ST_IDLE_RST: begin
                if (inhibit_done)   state_d = ST_RESET_SYNC;
            end
            ST_PD_SLEEP: begin
                if (hw_reset)       state_d = ST_RESET_SYNC;
                else if (wake_level) state_d = ST_PD_WAKE;
            end
            ST_PD_WAKE: begin
                if (hw_reset)         state_d = ST_RESET_SYNC;
                else if (!wake_level) state_d = ST_PD_SLEEP;
                else if (stable_done) state_d = ST_PD_RELEASE;
            end
            ST_PD_RELEASE: begin
                if (hw_reset)         state_d = ST_RESET_SYNC;
                else if (!wake_level) state_d = ST_INT_TAKE;
            end
            ST_INT_TAKE: begin
                state_d = hw_reset ? ST_RESET_SYNC : ST_RUN;
            end
            ST_RESET_SYNC: begin
                state_d = hw_reset ? ST_RESET_SYNC : ST_RUN;
            end
            default: state_d = ST_RESET_SYNC;
        endcase
    end

    always_comb begin
        osc_en      = 1'b1;
        core_clk_en = 1'b0;
        ram_inhibit = 1'b0;
        sfr_rst     = 1'b0;
        int_taken   = 1'b0;
        pin_mode    = PM_NONE;
        unique case (state_q)
            ST_RUN:        core_clk_en = 1'b1;
            ST_IDLE:       pin_mode    = PM_IDLE;
            ST_IDLE_RST: begin
                core_clk_en = 1'b1;
                ram_inhibit = 1'b1;
            end
            ST_PD_SLEEP: begin
                osc_en   = 1'b0;
                pin_mode = PM_PDOWN;
            end
            ST_PD_WAKE:    pin_mode    = PM_PDOWN;
            ST_PD_RELEASE: pin_mode    = PM_PDOWN;
            ST_INT_TAKE: begin
                core_clk_en = 1'b1;
                int_taken   = 1'b1;
            end
            ST_RESET_SYNC: begin
                core_clk_en = 1'b1;
                sfr_rst     = 1'b1;
            end
            default: sfr_rst = 1'b1;
        endcase
    end

    pwr_pin_table #(.PORT_CNT(PORT_CNT)) u_pins (
        .mode     (pin_mode),
        .prog_ext (prog_ext),
        .force_en (pin_force),
        .ale_val  (ale_val),
        .psen_val (psen_val),
        .port_sel (port_sel)
    );

endmodule

// File: rtl/pwr_mode_seq_chk.sv
module pwr_mode_seq_chk #(
    parameter int NUM_INT = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               hw_reset,
    input logic [NUM_INT-1:0] int_n,
    input logic [NUM_INT-1:0] int_en,
    input logic [NUM_INT-1:0] int_level,
    input logic               osc_en,
    input logic               core_clk_en,
    input logic               ram_inhibit,
    input logic               sfr_rst,
    input logic               int_taken,
    input logic               pin_force,
    input logic               ale_val,
    input logic               psen_val
);

    logic lvl_wake;
    assign lvl_wake = |(int_en & int_level & ~int_n);

    assert_osc_off_pd_pins_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_en |-> (!core_clk_en && pin_force && !ale_val && !psen_val));

    assert_idle_pins_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_force && ale_val) |-> (psen_val && osc_en && !core_clk_en));

    assert_sleep_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!osc_en && !hw_reset && !lvl_wake) |=> !osc_en);

    assert_int_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        int_taken |=> !int_taken);

    assert_inhibit_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ram_inhibit |-> (core_clk_en && !pin_force && !sfr_rst));

    assert_idle_reset_inhibit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_reset && pin_force && ale_val) |=> ram_inhibit);

    assert_pd_reset_direct_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_reset && pin_force && !ale_val) |=> (sfr_rst && !ram_inhibit));

    assert_reset_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (sfr_rst && hw_reset) |=> sfr_rst);

endmodule

bind pwr_mode_seq pwr_mode_seq_chk #(.NUM_INT(NUM_INT)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .hw_reset    (hw_reset),
    .int_n       (int_n),
    .int_en      (int_en),
    .int_level   (int_level),
    .osc_en      (osc_en),
    .core_clk_en (core_clk_en),
    .ram_inhibit (ram_inhibit),
    .sfr_rst     (sfr_rst),
    .int_taken   (int_taken),
    .pin_force   (pin_force),
    .ale_val     (ale_val),
    .psen_val    (psen_val)
);

// File: tb/test_pwr_mode_seq.sv
module test_pwr_mode_seq;

    localparam int STAB = 6;
    localparam int INH  = 3;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       hw_reset, req_idle, req_pdown, osc_ready, prog_ext;
    logic [1:0] int_n, int_en, int_level;
    logic       osc_en, core_clk_en, ram_inhibit, sfr_rst, int_taken;
    logic       pin_force, ale_val, psen_val;
    logic [7:0] port_sel;

    int    n_cmp = 0;
    int    n_bad = 0;
    string cur_req = "R11";
    bit    started = 0;

    always #5 clk = ~clk;

    pwr_mode_seq #(
        .NUM_INT(2), .PORT_CNT(4), .STABLE_CYCLES(STAB), .INHIBIT_CYCLES(INH)
    ) i_pwr_mode_seq (
        .clk(clk), .rst_n(rst_n), .hw_reset(hw_reset), .req_idle(req_idle),
        .req_pdown(req_pdown), .int_n(int_n), .int_en(int_en), .int_level(int_level),
        .osc_ready(osc_ready), .prog_ext(prog_ext), .osc_en(osc_en),
        .core_clk_en(core_clk_en), .ram_inhibit(ram_inhibit), .sfr_rst(sfr_rst),
        .int_taken(int_taken), .pin_force(pin_force), .ale_val(ale_val),
        .psen_val(psen_val), .port_sel(port_sel)
    );

    // Behavioural reference: mode numbers and cycle counters
    localparam int M_RUN = 0, M_IDLE = 1, M_IRST = 2, M_SLEEP = 3;
    localparam int M_WAKE = 4, M_REL = 5, M_INT = 6, M_RSY = 7;
    int m_mode = M_RSY;
    int m_stab = 0;
    int m_inh  = 0;

    always @(posedge clk or negedge rst_n) begin
        int  nxt;
        bit  lvl, anyi;
        if (!rst_n) begin
            m_mode = M_RSY; m_stab = 0; m_inh = 0;
        end else begin
            started = 1;
            lvl  = |(int_en & int_level & ~int_n);
            anyi = |(int_en & ~int_n);
            nxt  = m_mode;
            if (m_mode == M_RUN)        nxt = hw_reset ? M_RSY : req_pdown ? M_SLEEP : req_idle ? M_IDLE : M_RUN;
            else if (m_mode == M_IDLE)  nxt = hw_reset ? M_IRST : anyi ? M_INT : M_IDLE;
            else if (m_mode == M_IRST)  nxt = (m_inh >= INH - 1) ? M_RSY : M_IRST;
            else if (m_mode == M_SLEEP) nxt = hw_reset ? M_RSY : lvl ? M_WAKE : M_SLEEP;
            else if (m_mode == M_WAKE)  nxt = hw_reset ? M_RSY : !lvl ? M_SLEEP : (m_stab >= STAB) ? M_REL : M_WAKE;
            else if (m_mode == M_REL)   nxt = hw_reset ? M_RSY : !lvl ? M_INT : M_REL;
            else                        nxt = hw_reset ? M_RSY : M_RUN;
            if (m_mode != M_WAKE) m_stab = 0;
            else if (osc_ready && m_stab < STAB) m_stab++;
            if (m_mode != M_IRST) m_inh = 0;
            else m_inh++;
            m_mode = nxt;
        end
    end

    function automatic logic [15:0] expect_vec(int md, logic ext);
        logic o, c, r, s, t, f, a;
        logic [7:0] ps;
        o = (md != M_SLEEP);
        c = (md == M_RUN) || (md == M_IRST) || (md == M_INT) || (md == M_RSY);
        r = (md == M_IRST);
        s = (md == M_RSY);
        t = (md == M_INT);
        f = (md == M_IDLE) || (md == M_SLEEP) || (md == M_WAKE) || (md == M_REL);
        a = (md == M_IDLE);
        if (md == M_IDLE) ps = ext ? 8'h67 : 8'h55;
        else if (f)       ps = ext ? 8'h57 : 8'h55;
        else              ps = 8'h00;
        return {o, c, r, s, t, f, a, a, ps};
    endfunction

    always @(negedge clk) begin
        logic [15:0] got, exp;
        if (started) begin
            got = {osc_en, core_clk_en, ram_inhibit, sfr_rst, int_taken, pin_force,
                   ale_val, psen_val, port_sel};
            exp = expect_vec(m_mode, prog_ext);
            n_cmp++;
            if (got !== exp) begin
                n_bad++;
                $display("FAIL %s per-cycle: actual %h expected %h at %0t", cur_req, got, exp, $time);
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, got, exp, $time);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL %s watchdog: actual running expected finished", cur_req);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; hw_reset = 1'b0; req_idle = 1'b0; req_pdown = 1'b0;
        osc_ready = 1'b1; prog_ext = 1'b0;
        int_n = 2'b11; int_en = 2'b00; int_level = 2'b00;
        step(2);

        // R11: block reset state and held hardware reset
        cur_req = "R11";
        chk("R11", {sfr_rst, osc_en}, 2'b11);
        rst_n = 1'b1; hw_reset = 1'b1;
        step(3);
        chk("R11", sfr_rst, 1'b1);
        hw_reset = 1'b0;
        step(2);
        chk("R11", {core_clk_en, sfr_rst, port_sel}, {2'b10, 8'h00});

        // R2: idle with internal program memory
        cur_req = "R2";
        req_idle = 1'b1; step(1); req_idle = 1'b0; step(1);
        chk("R2", {osc_en, core_clk_en, ale_val, psen_val, port_sel}, {4'b1011, 8'h55});

        // R10: edge-configured enabled pin ends idle
        cur_req = "R10";
        int_en = 2'b01; int_level = 2'b00; int_n = 2'b10;
        step(1);
        chk("R10", {int_taken, core_clk_en}, 2'b11);
        step(1); int_n = 2'b11;
        chk("R10", {int_taken, core_clk_en, pin_force}, 3'b010);

        // R2/R8: idle with external memory, then reset inhibit window
        cur_req = "R2";
        prog_ext = 1'b1;
        req_idle = 1'b1; step(1); req_idle = 1'b0; step(1);
        chk("R2", port_sel, 8'h67);
        cur_req = "R8";
        hw_reset = 1'b1; step(1);
        chk("R8", {ram_inhibit, core_clk_en, pin_force}, 3'b110);
        hw_reset = 1'b0; step(INH - 1);
        chk("R8", ram_inhibit, 1'b1);
        step(1);
        chk("R8", {sfr_rst, ram_inhibit}, 2'b10);
        step(1);

        // R1/R3: power-down wins over idle, external memory pin table
        cur_req = "R1";
        req_idle = 1'b1; req_pdown = 1'b1; step(1);
        req_idle = 1'b0; req_pdown = 1'b0;
        chk("R1", {osc_en, core_clk_en}, 2'b00);
        cur_req = "R3";
        chk("R3", {ale_val, psen_val, pin_force, port_sel}, {3'b001, 8'h57});

        // R4: edge-configured and disabled pins do not wake
        cur_req = "R4";
        int_en = 2'b01; int_level = 2'b00; int_n = 2'b10; step(4);
        chk("R4", osc_en, 1'b0);
        int_en = 2'b00; int_level = 2'b11; int_n = 2'b00; step(4);
        chk("R4", osc_en, 1'b0);
        int_n = 2'b11; step(1);

        // R5: level wake restarts oscillator, count paused without osc_ready
        cur_req = "R5";
        int_en = 2'b10; int_level = 2'b10; osc_ready = 1'b0; int_n = 2'b01;
        step(1);
        chk("R5", {osc_en, pin_force, core_clk_en}, 3'b110);
        step(STAB + 3);
        chk("R5", {osc_en, pin_force, int_taken}, 3'b110);

        // R6: early releases fall back asleep; the count does not accumulate
        cur_req = "R6";
        osc_ready = 1'b1; step(3);
        int_n = 2'b11; step(1);
        chk("R6", osc_en, 1'b0);
        int_n = 2'b01; step(4);
        int_n = 2'b11; step(1);
        chk("R6", {osc_en, int_taken}, 2'b00);

        // R5/R7: full count, held until release, then interrupt pulse
        cur_req = "R5";
        int_n = 2'b01; step(STAB + 4);
        chk("R5", {osc_en, pin_force, int_taken, core_clk_en}, 4'b1100);
        cur_req = "R7";
        int_n = 2'b11; step(1);
        chk("R7", {int_taken, core_clk_en}, 2'b11);
        step(1);
        chk("R7", {int_taken, pin_force, core_clk_en}, 3'b001);

        // R3/R9: internal memory power-down, reset during wakeup and during sleep
        cur_req = "R3";
        prog_ext = 1'b0;
        req_pdown = 1'b1; step(1); req_pdown = 1'b0;
        chk("R3", {ale_val, psen_val, port_sel}, {2'b00, 8'h55});
        cur_req = "R9";
        int_n = 2'b01; step(2);
        chk("R9", osc_en, 1'b1);
        hw_reset = 1'b1; step(1);
        chk("R9", {sfr_rst, ram_inhibit}, 2'b10);
        hw_reset = 1'b0; int_n = 2'b11; step(2);
        req_pdown = 1'b1; step(1); req_pdown = 1'b0;
        chk("R9", osc_en, 1'b0);
        hw_reset = 1'b1; step(1);
        chk("R9", {sfr_rst, ram_inhibit, osc_en}, 3'b101);
        hw_reset = 1'b0; step(2);
        chk("R9", {core_clk_en, sfr_rst}, 2'b10);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule